// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds recently used virtual-to-physical page mappings so that a memory access can be translated without a page-table read. It has 32 slots, and every slot is compared against the lookup key in parallel. A lookup presents a 43-bit virtual address, an access kind (read or write) and the 2-bit privilege level of the requester. On the next clock edge the block registers three results: a hit flag, a 34-bit physical address and a permission-fault flag.

The low 13 address bits are the byte offset inside a page and are not translated. On a miss, logic outside the block walks the page table and installs the result through the fill port. A flush input clears every slot when the running process changes.

Each slot stores a valid bit, a 30-bit page tag, a 21-bit frame number and two 2-bit minimum-privilege levels, one for reads and one for writes. A fill chooses its slot in this order:
- the slot that already holds the same tag, if there is one;
- otherwise the lowest-numbered empty slot;
- otherwise a slot picked by a free-running 5-bit LFSR.

Top module: `pagemap_tlb`

## Requirements
- R1: After reset every slot is empty, `rsp_valid`, `rsp_hit` and `rsp_fault` are 0, and any lookup misses.
- R2: A lookup sampled with `lk_valid`=1 at a clock edge produces its result in the registers updated at that same edge: `rsp_valid` goes to 1 for exactly that cycle. When `lk_valid` was 0, `rsp_valid` and `rsp_hit` are 0.
- R3: A lookup hits when a valid slot holds the tag `lk_vaddr[42:13]`. The result is then `rsp_paddr` = {frame, `lk_vaddr[12:0]`}, with the frame in bits 33:13.
- R4: A lookup that misses returns `rsp_hit`=0, `rsp_paddr`=0 and `rsp_fault`=0.
- R5: On a hit, the block picks the slot's read level when `lk_write`=0 and its write level when `lk_write`=1. `rsp_fault` is 1 exactly when the unsigned `lk_priv` is lower than the picked level.
- R6: A fill whose tag is absent goes to the lowest-numbered empty slot. As a result, 32 fills with distinct tags into an empty table all stay resident.
- R7: A fill whose tag is already resident replaces that slot's frame and levels. No other slot changes, so no tag is ever held twice.
- R8: A fill with a new tag into a full table leaves the new mapping resident and evicts exactly one earlier mapping.
- R9: `flush` empties every slot at the clock edge that samples it.
- R10: A fill sampled together with `flush` is discarded.
- R11: A lookup sampled at the same edge as a fill or a flush sees the table contents from before that edge.
- R12: The offset bits `rsp_paddr[12:0]` of a hit are equal to `lk_vaddr[12:0]` of its lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 43 | Virtual address to translate |
| lk_write | input | 1 | Access kind: 0 read, 1 write |
| lk_priv | input | 2 | Privilege level of the requester |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | 30 | Page tag to install |
| fill_pfn | input | 21 | Frame number to install |
| fill_rd_lvl | input | 2 | Minimum privilege level for reads |
| fill_wr_lvl | input | 2 | Minimum privilege level for writes |
| flush | input | 1 | Empty all slots |
| rsp_valid | output | 1 | A result is present |
| rsp_hit | output | 1 | The translation was found |
| rsp_paddr | output | 34 | Physical address (0 on a miss) |
| rsp_fault | output | 1 | Privilege is too low for the access kind |

## Verification
Each pattern below separates one kind of fault from the others:

- **Filling the table with 32 distinct tags and reading them back** shows whether slots are allocated without overwriting each other.
- **Refilling a resident tag** shows whether the block updates that slot in place or creates a duplicate.
- **A 33rd tag** shows that a full table evicts exactly one mapping.
- **Lookups issued in the same cycle as a fill or a flush** show whether the result reflects the old or the new contents.
- **Privilege sweeps around the stored levels, with both access kinds,** expose off-by-one errors and a swap of the read and write fields.
- **A long random mix** of fills, refills and lookups over a pool of tags smaller than the table, with random offsets, levels and privileges, is checked against a bench model that never has to predict a random eviction.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_e;

  // Galois feedback masks for maximal-length LFSRs, 2 to 8 bits
  function automatic logic [7:0] lfsr_taps(input int w);
    case (w)
      2:       return 8'b0000_0011;
      3:       return 8'b0000_0110;
      4:       return 8'b0000_1100;
      5:       return 8'b0001_0100;
      6:       return 8'b0011_0000;
      7:       return 8'b0110_0000;
      8:       return 8'b1011_1000;
      default: return 8'b0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 32,
  parameter int TAG_W = 30
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [TAG_W-1:0]          key,
  input  logic [N-1:0][TAG_W-1:0]   tags,
  input  logic [N-1:0]              valid,
  output logic [N-1:0]              hits
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hits[g] = valid[g] && (tags[g] == key);
    end
  endgenerate

  // R7: a tag is never resident in two slots
  dup_free_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(hits));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     free,
  input  logic [N-1:0]     dup,
  output logic [IDX_W-1:0] pick
);

  localparam logic [IDX_W-1:0] TAPS = IDX_W'(xlt_pkg::lfsr_taps(IDX_W));

  logic [IDX_W-1:0] lfsr;
  logic [IDX_W-1:0] dup_idx;
  logic [IDX_W-1:0] free_idx;
  logic             have_free;

  always_ff @(posedge clk) begin
    if (rst) lfsr <= IDX_W'(1);
    else     lfsr <= (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
  end

  always_comb begin
    dup_idx   = '0;
    free_idx  = '0;
    have_free = 1'b0;
    for (int i = 0; i < N; i++)
      if (dup[i]) dup_idx = IDX_W'(i);
    for (int i = N - 1; i >= 0; i--)
      if (free[i]) begin
        free_idx  = IDX_W'(i);
        have_free = 1'b1;
      end
    if (|dup)          pick = dup_idx;
    else if (have_free) pick = free_idx;
    else               pick = lfsr;
  end

  // R6: with no matching tag and a free slot, the pick is free
  free_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (!(|dup) && (|free)) |-> free[pick]);

  // R8: the random source never locks up at zero
  lfsr_live_chk: assert property (@(posedge clk) disable iff (rst) lfsr != '0);

endmodule

// File: rtl/tlb_sel_mux.sv
module tlb_sel_mux #(
  parameter int N = 32,
  parameter int W = 25
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] data,
  output logic [W-1:0]        out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < N; i++)
      if (sel[i]) out = out | data[i];
  end

endmodule

// File: rtl/pagemap_tlb.sv
module pagemap_tlb #(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 43,
  parameter int OFF_W   = 13,
  parameter int PFN_W   = 21,
  parameter int LVL_W   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [VA_W-1:0]         lk_vaddr,
  input  logic                    lk_write,
  input  logic [LVL_W-1:0]        lk_priv,
  input  logic                    fill_en,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]        fill_pfn,
  input  logic [LVL_W-1:0]        fill_rd_lvl,
  input  logic [LVL_W-1:0]        fill_wr_lvl,
  input  logic                    flush,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic [PFN_W+OFF_W-1:0]  rsp_paddr,
  output logic                    rsp_fault
);

  localparam int TAG_W = VA_W - OFF_W;
  localparam int PA_W  = PFN_W + OFF_W;
  localparam int PAY_W = PFN_W + 2 * LVL_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]              ent_valid;
  logic [ENTRIES-1:0][TAG_W-1:0]   ent_tag;
  logic [ENTRIES-1:0][PAY_W-1:0]   ent_pay;

  logic [TAG_W-1:0]   lk_tag;
  logic [ENTRIES-1:0] lk_hits;
  logic [ENTRIES-1:0] fill_hits;
  logic [IDX_W-1:0]   fill_slot;
  logic [PAY_W-1:0]   sel_pay;
  logic [PFN_W-1:0]   sel_pfn;
  logic [LVL_W-1:0]   sel_rd;
  logic [LVL_W-1:0]   sel_wr;
  logic [LVL_W-1:0]   need_lvl;
  logic               any_hit;
  xlt_pkg::acc_e      acc;

  assign lk_tag = lk_vaddr[VA_W-1:OFF_W];
  assign acc    = xlt_pkg::acc_e'(lk_write);

  tlb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst(rst), .key(lk_tag), .tags(ent_tag),
    .valid(ent_valid), .hits(lk_hits)
  );

  tlb_match #(.N(ENTRIES), .TAG_W(TAG_W)) u_fill_match (
    .clk(clk), .rst(rst), .key(fill_vpn), .tags(ent_tag),
    .valid(ent_valid), .hits(fill_hits)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst(rst), .free(~ent_valid), .dup(fill_hits), .pick(fill_slot)
  );

  tlb_sel_mux #(.N(ENTRIES), .W(PAY_W)) u_mux (
    .sel(lk_hits), .data(ent_pay), .out(sel_pay)
  );

  assign {sel_pfn, sel_rd, sel_wr} = sel_pay;
  assign any_hit  = |lk_hits;
  assign need_lvl = (acc == xlt_pkg::ACC_WRITE) ? sel_wr : sel_rd;

  // slot storage: only the valid bits are reset
  always_ff @(posedge clk) begin
    if (rst)
      ent_valid <= '0;
    else if (flush)
      ent_valid <= '0;
    else if (fill_en)
      ent_valid[fill_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      ent_tag[fill_slot] <= fill_vpn;
      ent_pay[fill_slot] <= {fill_pfn, fill_rd_lvl, fill_wr_lvl};
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && any_hit;
      rsp_fault <= lk_valid && any_hit && (lk_priv < need_lvl);
      rsp_paddr <= (lk_valid && any_hit) ?
                   PA_W'({sel_pfn, lk_vaddr[OFF_W-1:0]}) : '0;
    end
  end

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0));

  // R5
  fault_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_hit);

  // R4
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_fault));

  // R12
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> (rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(lk_valid) |-> (!rsp_valid && !rsp_hit));

endmodule

// File: tb/pagemap_tlb_test.sv
module pagemap_tlb_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid;
  logic [42:0] lk_vaddr;
  logic        lk_write;
  logic [1:0]  lk_priv;
  logic        fill_en;
  logic [29:0] fill_vpn;
  logic [20:0] fill_pfn;
  logic [1:0]  fill_rd_lvl;
  logic [1:0]  fill_wr_lvl;
  logic        flush;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [33:0] rsp_paddr;
  logic        rsp_fault;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model of resident mappings
  bit          m_v   [64];
  logic [29:0] m_tag [64];
  logic [20:0] m_pfn [64];
  logic [1:0]  m_rd  [64];
  logic [1:0]  m_wr  [64];

  logic [29:0] pool [24];

  always #4 clk = ~clk;

  pagemap_tlb uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_write(lk_write), .lk_priv(lk_priv), .fill_en(fill_en),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fill_rd_lvl(fill_rd_lvl),
    .fill_wr_lvl(fill_wr_lvl), .flush(flush), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault)
  );

  function automatic int m_find(input logic [29:0] t);
    for (int i = 0; i < 64; i++)
      if (m_v[i] && m_tag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_free();
    for (int i = 0; i < 64; i++)
      if (!m_v[i]) return i;
    return -1;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle: inputs driven at a falling edge, outputs checked at the next one
  task automatic step(input string req, input bit lv, input logic [42:0] va,
                      input bit wr, input logic [1:0] pr, input bit fe,
                      input logic [29:0] ft, input logic [20:0] fp,
                      input logic [1:0] frd, input logic [1:0] fwr,
                      input bit fl);
    int          k;
    bit          e_hit;
    bit          e_flt;
    logic [33:0] e_pa;
    lk_valid = lv; lk_vaddr = va; lk_write = wr; lk_priv = pr;
    fill_en = fe; fill_vpn = ft; fill_pfn = fp;
    fill_rd_lvl = frd; fill_wr_lvl = fwr; flush = fl;
    k     = m_find(va[42:13]);
    e_hit = lv && (k >= 0);
    e_pa  = e_hit ? {m_pfn[k], va[12:0]} : 34'd0;
    e_flt = e_hit && (pr < (wr ? m_wr[k] : m_rd[k]));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    end else if (fe) begin
      k = m_find(ft);
      if (k < 0) k = m_free();
      if (k >= 0) begin
        m_v[k] = 1'b1; m_tag[k] = ft; m_pfn[k] = fp;
        m_rd[k] = frd; m_wr[k] = fwr;
      end
    end
    @(negedge clk);
    lk_valid = 1'b0; fill_en = 1'b0; flush = 1'b0;
    check(req, "rsp_valid", 64'(rsp_valid), 64'(lv));
    if (lv) begin
      check(req, "rsp_hit",   64'(rsp_hit),   64'(e_hit));
      check(req, "rsp_paddr", 64'(rsp_paddr), 64'(e_pa));
      check(req, "rsp_fault", 64'(rsp_fault), 64'(e_flt));
    end else begin
      check(req, "rsp_hit idle", 64'(rsp_hit), 64'd0);
    end
  endtask

  task automatic look(input string req, input logic [29:0] t,
                      input logic [12:0] off, input bit wr, input logic [1:0] pr);
    step(req, 1'b1, {t, off}, wr, pr, 1'b0, '0, '0, '0, '0, 1'b0);
  endtask

  task automatic fill(input string req, input logic [29:0] t,
                      input logic [20:0] p, input logic [1:0] rl, input logic [1:0] wl);
    step(req, 1'b0, '0, 1'b0, 2'd0, 1'b1, t, p, rl, wl, 1'b0);
  endtask

  task automatic probe(input logic [29:0] t, output bit h);
    lk_valid = 1'b1; lk_vaddr = {t, 13'h0}; lk_write = 1'b0; lk_priv = 2'd3;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    h = rsp_hit;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int  hits;
    bit  h;
    bit  new_hit;
    void'($urandom(32'd7021));
    for (int i = 0; i < 64; i++) m_v[i] = 1'b0;
    rst = 1'b1; lk_valid = 0; lk_vaddr = '0; lk_write = 0; lk_priv = 0;
    fill_en = 0; fill_vpn = '0; fill_pfn = '0; fill_rd_lvl = 0; fill_wr_lvl = 0;
    flush = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1", "rsp_hit",   64'(rsp_hit),   64'd0);
    check("R1", "rsp_fault", 64'(rsp_fault), 64'd0);
    look("R1", 30'h0, 13'h123, 1'b0, 2'd3);
    look("R1", 30'h2ABCDEF1, 13'h1FFF, 1'b1, 2'd0);

    // R6 / R3 / R12: 32 distinct fills then read back with varied offsets
    for (int i = 0; i < 32; i++)
      fill("R6", 30'(i * 32'h0123_4567 + 32'h11), 21'(i * 32'h3_1337 + 1), 2'd0, 2'd0);
    for (int i = 0; i < 32; i++)
      look("R3", 30'(i * 32'h0123_4567 + 32'h11), 13'(i * 257), i[0], 2'd0);
    look("R12", 30'(5 * 32'h0123_4567 + 32'h11), 13'h1FFF, 1'b0, 2'd0);
    look("R4", 30'h3FFF_FFFF, 13'h0AA, 1'b0, 2'd3);

    // R7: refill a resident tag; all 32 stay resident with one update
    fill("R7", 30'(5 * 32'h0123_4567 + 32'h11), 21'h1ABCDE, 2'd1, 2'd2);
    for (int i = 0; i < 32; i++)
      look("R7", 30'(i * 32'h0123_4567 + 32'h11), 13'h0F0, 1'b0, 2'd3);

    // R8: 33rd tag into a full table
    fill_en = 1'b1; fill_vpn = 30'h3FFF_FFFF; fill_pfn = 21'h0F0F0;
    fill_rd_lvl = 0; fill_wr_lvl = 0;
    @(posedge clk);
    @(negedge clk);
    fill_en = 1'b0;
    hits = 0;
    for (int i = 0; i < 32; i++) begin
      probe(30'(i * 32'h0123_4567 + 32'h11), h);
      if (h) hits++;
    end
    probe(30'h3FFF_FFFF, new_hit);
    check("R8", "new mapping resident", 64'(new_hit), 64'd1);
    check("R8", "old mappings kept", 64'(hits), 64'd31);

    // R9: flush empties the table (model cleared by step)
    step("R9", 1'b0, '0, 1'b0, 2'd0, 1'b0, '0, '0, '0, '0, 1'b1);
    look("R9", 30'h3FFF_FFFF, 13'h0, 1'b0, 2'd3);
    look("R9", 30'(7 * 32'h0123_4567 + 32'h11), 13'h0, 1'b0, 2'd3);

    // R10: fill together with flush is discarded
    step("R10", 1'b0, '0, 1'b0, 2'd0, 1'b1, 30'h1234, 21'h55, '0, '0, 1'b1);
    look("R10", 30'h1234, 13'h10, 1'b0, 2'd3);

    // R11: same-cycle lookup sees old contents
    step("R11", 1'b1, {30'h777, 13'h4}, 1'b0, 2'd3, 1'b1, 30'h777, 21'h99, '0, '0, 1'b0);
    look("R11", 30'h777, 13'h4, 1'b0, 2'd3);
    step("R11", 1'b1, {30'h777, 13'h8}, 1'b0, 2'd3, 1'b0, '0, '0, '0, '0, 1'b1);
    look("R11", 30'h777, 13'h8, 1'b0, 2'd3);

    // R5: privilege sweep around stored levels
    fill("R5", 30'h0BEEF, 21'h0CAFE, 2'd2, 2'd3);
    for (int p = 0; p < 4; p++) begin
      look("R5", 30'h0BEEF, 13'h020, 1'b0, 2'(p));
      look("R5", 30'h0BEEF, 13'h020, 1'b1, 2'(p));
    end
    fill("R5", 30'h0BEEF, 21'h0CAFE, 2'd3, 2'd1);
    look("R5", 30'h0BEEF, 13'h1, 1'b0, 2'd2);
    look("R5", 30'h0BEEF, 13'h1, 1'b1, 2'd1);
    step("R9", 1'b0, '0, 1'b0, 2'd0, 1'b0, '0, '0, '0, '0, 1'b1);

    // random mix over a pool smaller than the table (R2 R3 R4 R5 R7 R11)
    for (int i = 0; i < 24; i++) pool[i] = 30'($urandom);
    for (int n = 0; n < 3000; n++) begin
      int sel;
      bit lv;
      bit fe;
      logic [29:0] lt;
      sel = int'($urandom_range(0, 23));
      lv  = ($urandom_range(0, 3) != 0);
      fe  = ($urandom_range(0, 2) == 0);
      lt  = ($urandom_range(0, 4) == 0) ? 30'($urandom) : pool[int'($urandom_range(0, 23))];
      step("R2", lv, {lt, 13'($urandom)}, 1'($urandom), 2'($urandom),
           fe, pool[sel], 21'($urandom), 2'($urandom), 2'($urandom), 1'b0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule